// File: doc/BRIEF.md
# I/Q DC Offset Canceller with Silent-Window Calibration

This block removes a fixed DC offset from the in-phase and quadrature sample streams of a direct-conversion receiver. In such a receiver, leakage of the local oscillator into the mixer input shows up as a constant bias on both baseband channels. The bias is largest, relative to the signal, at low input levels.

Calibration is started with a single-cycle pulse. The surrounding system must keep the receiver input silent while calibration runs. For each channel, the block sums a fixed number of valid samples, which is about 4 µs of input at the configured sample rate. The window is rounded down to a power of two so that the average is a plain arithmetic shift. At the end of the window, the block stores the negated average as that channel's correction and raises a done flag. From then on, every sample is passed through with the stored correction added, and the sum is clamped to the output range.

The correction does not track the offset. It stays frozen until the next calibration pulse. Before the first calibration, the correction is zero and the block passes samples through unchanged.

Top module: `dc_offset_canceller`

## Requirements
- R1: While reset is applied, and for the cycles in which the synchronised reset is still active, `out_valid`, `cal_busy` and `cal_done` are low, `out_i` and `out_q` are zero, and both stored corrections are zero.
- R2: Each output sample is registered once, so `out_valid` equals `in_valid` of the previous cycle. Before any calibration has completed, a valid output equals its input sample unchanged.
- R3: A cycle with `cal_start` high sets `cal_busy` and clears `cal_done` on the next cycle, and empties both accumulators. The sample presented in that same cycle is not summed. A `cal_start` that arrives while a window is in progress discards the partial sum and starts a fresh window.
- R4: The window length is N = 2^floor(log2(SAMPLE_RATE_KHZ*CAL_TIME_NS/10^6)) valid samples, which is 64 at the defaults (20000 kHz, 4000 ns). Cycles with `in_valid` low are not counted. After N-1 valid samples, `cal_busy` is still high and `cal_done` is still low.
- R5: At the end of a window, each channel's correction becomes -floor(sum/N), clamped to the signed DATA_W range. For example, a mean of -2048 with DATA_W=12 gives a correction of +2047. The I and Q channels are estimated independently.
- R6: On the cycle after the N-th valid sample, `cal_busy` is low and `cal_done` is high; the two flags are never high together. The N-th sample's own output still uses the previous correction, and the new correction applies from the next sample.
- R7: Once latched, a correction stays constant, whatever samples arrive, until a later window completes.
- R8: A valid output equals in + correction, clamped to [-2^(DATA_W-1), 2^(DATA_W-1)-1]. It never wraps.
- R9: While a window is running, outputs continue to use the correction held before the window started, which is zero if no window has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input sample qualifier |
| in_i | input | DATA_W | Signed in-phase sample |
| in_q | input | DATA_W | Signed quadrature sample |
| cal_start | input | 1 | Single-cycle pulse that starts (or restarts) calibration |
| out_valid | output | 1 | Output sample qualifier, one cycle after `in_valid` |
| out_i | output | DATA_W | Corrected, saturated in-phase sample |
| out_q | output | DATA_W | Corrected, saturated quadrature sample |
| cal_busy | output | 1 | Calibration window in progress |
| cal_done | output | 1 | A correction has been latched since the last start pulse |

## Verification
The hardest conditions to reach are those where the correction itself saturates and where a window finishes on the exact valid sample that follows gaps in `in_valid`. Only a full window of extreme constant input, presented with irregular gaps, exercises both together. The stimulus runs one window with random idle cycles and small random noise on a known offset, and checks the flags at the N-1 and N sample boundaries. A second window feeds the most negative value on I and the most positive on Q, which forces a clamped correction. Full-scale samples are then pushed through both adders, and a restart in the middle of a window shows that the partial sum is discarded.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

  typedef enum logic [1:0] {
    CAL_IDLE = 2'd0,
    CAL_RUN  = 2'd1,
    CAL_HELD = 2'd2
  } cal_state_e;

  localparam int unsigned NUM_CH = 2;

endpackage

// File: rtl/dcc_rst_sync.sv
module dcc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/dcc_window_ctrl.sv
module dcc_window_ctrl #(
  parameter int unsigned WIN_LOG2 = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cal_start,
  input  logic in_valid,
  output logic acc_clr,
  output logic acc_en,
  output logic latch,
  output logic busy,
  output logic done
);
  import dcc_pkg::*;

  localparam int unsigned CNT_W = WIN_LOG2;
  localparam logic [CNT_W-1:0] LAST = CNT_W'((1 << WIN_LOG2) - 1);

  cal_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    acc_clr = 1'b0;
    acc_en  = 1'b0;
    latch   = 1'b0;
    if (cal_start) begin
      state_d = CAL_RUN;
      cnt_d   = '0;
      acc_clr = 1'b1;
    end else if (state_q == CAL_RUN && in_valid) begin
      acc_en = 1'b1;
      if (cnt_q == LAST) begin
        latch   = 1'b1;
        state_d = CAL_HELD;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CAL_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy = (state_q == CAL_RUN);
  assign done = (state_q == CAL_HELD);

endmodule

// File: rtl/dcc_estimator.sv
module dcc_estimator #(
  parameter int unsigned DATA_W   = 12,
  parameter int unsigned WIN_LOG2 = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc_clr,
  input  logic                     acc_en,
  input  logic                     latch,
  input  logic signed [DATA_W-1:0] sample,
  output logic signed [DATA_W-1:0] corr
);

  localparam int unsigned ACC_W = DATA_W + WIN_LOG2;
  localparam logic signed [DATA_W-1:0] S_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] S_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [ACC_W-1:0]  acc_q, acc_d, acc_sum, acc_shr;
  logic signed [DATA_W:0]   mean_v, neg_v;
  logic signed [DATA_W-1:0] neg_sat, corr_q, corr_d;

  // next-state logic
  always_comb begin
    acc_sum = acc_q + {{WIN_LOG2{sample[DATA_W-1]}}, sample};
    acc_shr = acc_sum >>> WIN_LOG2;
    mean_v  = acc_shr[DATA_W:0];
    neg_v   = -mean_v;
    if (neg_v[DATA_W] != neg_v[DATA_W-1]) neg_sat = neg_v[DATA_W] ? S_MIN : S_MAX;
    else                                  neg_sat = neg_v[DATA_W-1:0];

    acc_d = acc_q;
    if (acc_clr)     acc_d = '0;
    else if (acc_en) acc_d = acc_sum;

    corr_d = corr_q;
    if (latch) corr_d = neg_sat;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      corr_q <= '0;
    end else begin
      if (acc_clr || acc_en) acc_q  <= acc_d;
      if (latch)             corr_q <= corr_d;
    end
  end

  assign corr = corr_q;

endmodule

// File: rtl/dcc_correct.sv
module dcc_correct #(
  parameter int unsigned DATA_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] sample,
  input  logic signed [DATA_W-1:0] corr,
  output logic signed [DATA_W-1:0] out_sample
);

  localparam logic signed [DATA_W-1:0] S_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] S_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [DATA_W:0]   sum_v;
  logic signed [DATA_W-1:0] out_d, out_q;

  // next-state logic
  always_comb begin
    sum_v = {sample[DATA_W-1], sample} + {corr[DATA_W-1], corr};
    if (sum_v[DATA_W] != sum_v[DATA_W-1]) out_d = sum_v[DATA_W] ? S_MIN : S_MAX;
    else                                  out_d = sum_v[DATA_W-1:0];
  end

  // register with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out_q <= '0;
    else if (in_valid) out_q <= out_d;
  end

  assign out_sample = out_q;

endmodule

// File: rtl/dc_offset_canceller.sv
module dc_offset_canceller #(
  parameter int unsigned DATA_W          = 12,
  parameter int unsigned SAMPLE_RATE_KHZ = 20000,
  parameter int unsigned CAL_TIME_NS     = 4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_i,
  input  logic [DATA_W-1:0] in_q,
  input  logic              cal_start,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_i,
  output logic [DATA_W-1:0] out_q,
  output logic              cal_busy,
  output logic              cal_done
);
  import dcc_pkg::*;

  localparam int unsigned WIN_RAW  = (SAMPLE_RATE_KHZ * CAL_TIME_NS) / 1000000;
  localparam int unsigned WIN_LOG2 = $clog2(WIN_RAW + 1) - 1;

  logic rst_sync_n;
  logic acc_clr, acc_en, latch;
  logic valid_q;

  logic signed [DATA_W-1:0] in_ch   [NUM_CH];
  logic signed [DATA_W-1:0] corr_ch [NUM_CH];
  logic signed [DATA_W-1:0] out_ch  [NUM_CH];

  dcc_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dcc_window_ctrl #(.WIN_LOG2(WIN_LOG2)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cal_start (cal_start),
    .in_valid  (in_valid),
    .acc_clr   (acc_clr),
    .acc_en    (acc_en),
    .latch     (latch),
    .busy      (cal_busy),
    .done      (cal_done)
  );

  assign in_ch[0] = in_i;
  assign in_ch[1] = in_q;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    dcc_estimator #(.DATA_W(DATA_W), .WIN_LOG2(WIN_LOG2)) u_est (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .acc_clr (acc_clr),
      .acc_en  (acc_en),
      .latch   (latch),
      .sample  (in_ch[ch]),
      .corr    (corr_ch[ch])
    );

    dcc_correct #(.DATA_W(DATA_W)) u_cor (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .in_valid   (in_valid),
      .sample     (in_ch[ch]),
      .corr       (corr_ch[ch]),
      .out_sample (out_ch[ch])
    );
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) valid_q <= 1'b0;
    else             valid_q <= in_valid;
  end

  assign out_valid = valid_q;
  assign out_i     = out_ch[0];
  assign out_q     = out_ch[1];

endmodule

// File: rtl/dcc_checker.sv
module dcc_checker #(
  parameter int unsigned DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cal_start,
  input logic              in_valid,
  input logic              out_valid,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] corr_i,
  input logic [DATA_W-1:0] corr_q
);

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> (busy && !done));

  p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_done_from_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  p_hold_i_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cal_start) |=> $stable(corr_i));

  p_hold_q_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cal_start) |=> $stable(corr_q));

endmodule

bind dc_offset_canceller dcc_checker #(.DATA_W(DATA_W)) u_dcc_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cal_start (cal_start),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .busy      (cal_busy),
  .done      (cal_done),
  .corr_i    (corr_ch[0]),
  .corr_q    (corr_ch[1])
);

// File: tb/dc_offset_canceller_bench.sv
module dc_offset_canceller_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 12;
  localparam int WIN_N      = 64;   // R4: 2^floor(log2(80))
  localparam int SMAX       = 2047;
  localparam int SMIN       = -2048;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, cal_start;
  logic [W-1:0] in_i, in_q;
  logic         out_valid, cal_busy, cal_done;
  logic [W-1:0] out_i, out_q;

  int errors = 0;
  int checks = 0;
  string cur_tag = "R2";

  // reference model state
  int  m_corr_i = 0, m_corr_q = 0;
  longint m_acc_i = 0, m_acc_q = 0;
  int  m_cnt = 0;
  bit  m_busy = 0, m_done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dc_offset_canceller u_dc_offset_canceller (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_i      (in_i),
    .in_q      (in_q),
    .cal_start (cal_start),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q),
    .cal_busy  (cal_busy),
    .cal_done  (cal_done)
  );

  function automatic int sat(longint v);
    if (v > SMAX) return SMAX;
    if (v < SMIN) return SMIN;
    return int'(v);
  endfunction

  function automatic int sx(logic [W-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one sample cycle: drive, clock, compare against model, update model
  task automatic step(bit v, int i, int q, bit cs);
    int ei, eq;
    in_valid  = v;
    in_i      = W'(i);
    in_q      = W'(q);
    cal_start = cs;
    ei = sat(longint'(i) + m_corr_i);
    eq = sat(longint'(q) + m_corr_q);
    @(posedge clk);
    @(negedge clk);
    chk("R2 out_valid", int'(out_valid), int'(v));
    if (v) begin
      chk({cur_tag, " out_i"}, sx(out_i), ei);
      chk({cur_tag, " out_q"}, sx(out_q), eq);
    end
    if (cs) begin
      m_busy = 1; m_done = 0; m_cnt = 0; m_acc_i = 0; m_acc_q = 0;
    end else if (m_busy && v) begin
      m_acc_i += i; m_acc_q += q; m_cnt++;
      if (m_cnt == WIN_N) begin
        m_corr_i = sat(-(m_acc_i >>> 6));
        m_corr_q = sat(-(m_acc_q >>> 6));
        m_busy = 0; m_done = 1;
      end
    end
    chk("R3 cal_busy", int'(cal_busy), int'(m_busy));
    chk("R6 cal_done", int'(cal_done), int'(m_done));
    in_valid  = 0;
    cal_start = 0;
  endtask

  task automatic run_window(int off_i, int off_q, int noise, bit gaps);
    int n;
    n = 0;
    while (n < WIN_N) begin
      if (gaps && ($urandom % 3 == 0)) step(0, 0, 0, 0);
      else begin
        step(1, off_i + int'($urandom % (2*noise+1)) - noise,
                off_q + int'($urandom % (2*noise+1)) - noise, 0);
        n++;
        if (n == WIN_N-1) begin
          chk("R4 busy at N-1", int'(cal_busy), 1);
          chk("R4 done at N-1", int'(cal_done), 0);
        end
      end
    end
    chk("R4 done at N", int'(cal_done), 1);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; in_valid = 0; cal_start = 0; in_i = '0; in_q = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 busy", int'(cal_busy), 0);
    chk("R1 done", int'(cal_done), 0);
    chk("R1 out_i", sx(out_i), 0);
    chk("R1 out_q", sx(out_q), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R2: pass-through before calibration, random valid pattern
    cur_tag = "R2";
    for (int k = 0; k < 30; k++)
      step(bit'($urandom % 2), int'($urandom % 4096) - 2048,
           int'($urandom % 4096) - 2048, 0);

    // R9/R4: calibrate with gaps and noise; outputs still uncorrected
    cur_tag = "R9";
    step(1, 500, -500, 1);
    run_window(37, -120, 3, 1);

    // R5: zero input shows the correction directly
    cur_tag = "R5";
    for (int k = 0; k < 4; k++) step(1, 0, 0, 0);
    // R5: noiseless constant offset gives exact negation
    step(0, 0, 0, 1);
    run_window(-300, 211, 0, 0);
    step(1, 0, 0, 0);
    chk("R5 corr_i exact", sx(out_i), 300);
    chk("R5 corr_q exact", sx(out_q), -211);

    // R7: correction frozen under random traffic
    cur_tag = "R7";
    for (int k = 0; k < 150; k++)
      step(bit'($urandom % 4 != 0), int'($urandom % 4096) - 2048,
           int'($urandom % 4096) - 2048, 0);
    step(1, 0, 0, 0);
    chk("R7 corr_i still", sx(out_i), 300);

    // R3: restart mid-window discards partial sum; R9 old corr used meanwhile
    cur_tag = "R9";
    step(0, 0, 0, 1);
    for (int k = 0; k < 30; k++) step(1, 1000, 1000, 0);
    step(1, 5, 5, 1);
    chk("R3 busy after restart", int'(cal_busy), 1);
    run_window(SMIN, SMAX, 0, 1);

    // R5/R8: saturated corrections and saturated sums
    cur_tag = "R8";
    step(1, 0, 0, 0);
    chk("R5 sat corr_i", sx(out_i), SMAX);
    chk("R5 corr_q", sx(out_q), -SMAX);
    step(1, SMAX, SMIN, 0);
    chk("R8 pos clamp", sx(out_i), SMAX);
    chk("R8 neg clamp", sx(out_q), SMIN);
    step(1, SMIN, SMAX, 0);
    chk("R8 no clamp i", sx(out_i), -1);
    chk("R8 no clamp q", sx(out_q), 0);
    for (int k = 0; k < 40; k++)
      step(1, int'($urandom % 4096) - 2048, int'($urandom % 4096) - 2048, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule